// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that software controls through a five-word register window on a simple synchronous register bus. The control path is gated by 16-bit magic values written to a key register. One value opens the prescaler and reload registers for writing and another closes them. A third value starts the countdown, and a fourth refreshes it. Once the timer is started, software cannot stop it. Only the block reset returns it to idle.

A free-running divider turns the system clock into prescaled ticks. A 12-bit down-counter loses one count per tick. The tick after the count reaches zero raises a one-cycle reset request and reloads the count. New prescaler and reload values take effect only after a fixed number of prescaled ticks, which models the slow-clock crossing. A busy flag for each register reports while its update is still pending. Software programs the block in this order: open access, write the divider code and the reload value, start the timer, wait for both busy flags to clear, then refresh.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the prescaler register reads 0, the reload register reads 0xFFF and the status register reads 0. The reset request output is low and the counter is stopped.
- R2: Reads at byte offset 0x00 (key) return 0, and so do reads at the unused window slot 0x10 and at any other unmapped offset. The prescaler is at 0x04, the reload at 0x08 and the status at 0x0C, and every bit of these three registers above its defined field reads 0.
- R3: Writing 0x5555 into key bits [15:0] opens writes to the prescaler and reload registers, and writing 0x0000 closes them. Writes to 0x04 or 0x08 while access is closed change neither the stored value nor the status flags.
- R4: Any other key value has no effect. It does not open or close access, does not start the timer and does not refresh it.
- R5: The prescaler code is bits [2:0] at 0x04. Codes 0 to 6 give one tick every 4, 8, 16, 32, 64, 128 or 256 clocks, and code 7 behaves as code 6.
- R6: The reload value is bits [11:0] at 0x08. Higher bits of the write are dropped.
- R7: An accepted prescaler write sets status bit 0 and an accepted reload write sets status bit 1 from the next cycle. Each bit clears when SYNC_TICKS prescaled ticks have passed, and only then does the counter use the new value. A new write restarts the wait.
- R8: Writing 0xCCCC starts the timer. It loads the counter with the applied reload value and restarts the divider phase. No reset request is raised before the start.
- R9: Writing 0xAAAA loads the counter with the applied reload value and restarts the divider phase, which delays the next timeout to a full period after the write.
- R10: With reload value R and divide ratio D, the reset request is high for exactly one cycle, (R+1)*D clock edges after the start or refresh write edge. The counter then reloads and the request repeats every (R+1)*D cycles.
- R11: Once started, the timer keeps running. Writing 0x0000 or any other key value does not stop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not selected |
| wdt_reset_req | output | 1 | One-cycle timeout pulse |

## Verification
The hardest condition to reach from the ports is a divider change that lands while the counter is running. Applying a new divide ratio in the middle of a count leaves the divider at an arbitrary phase, so the timeout cycle cannot be predicted at that point. The stimulus therefore mutes the pulse scoreboard while the prescaler update is pending and polls the status register until bit 0 clears. It then issues a refresh, which realigns the divider, and expects pulses at exact multiples of the new period. The update latency is also bounded from both sides: the busy flag must still be set after (SYNC_TICKS-1)*4 cycles and must be clear soon after SYNC_TICKS*4 cycles.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W     = 16;
  localparam int PRE_W     = 3;
  localparam int RLD_W     = 12;
  localparam int BASE_LOG2 = 2;
  localparam int MAX_CODE  = 6;
  localparam int DIV_W     = BASE_LOG2 + MAX_CODE;

  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_CLOSE   = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

  localparam int OFS_KEY  = 'h00;
  localparam int OFS_PRE  = 'h04;
  localparam int OFS_RLD  = 'h08;
  localparam int OFS_STAT = 'h0C;

  localparam logic [RLD_W-1:0] RLD_RESET = '1;

  typedef enum logic [2:0] {
    EV_NONE, EV_OPEN, EV_CLOSE, EV_START, EV_REFRESH
  } key_ev_e;

  // divisor minus one for a prescaler code; codes past MAX_CODE saturate
  function automatic logic [DIV_W-1:0] div_limit(input logic [PRE_W-1:0] code);
    int unsigned sh;
    sh = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    return DIV_W'((1 << (sh + BASE_LOG2)) - 1);
  endfunction

  // clock edges from start/refresh to the timeout pulse
  function automatic int unsigned period_cycles(input logic [RLD_W-1:0] rld,
                                                input logic [PRE_W-1:0] code);
    return (int'(rld) + 1) * (int'(div_limit(code)) + 1);
  endfunction
endpackage

// File: rtl/kwd_keydec.sv
module kwd_keydec
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             unlocked,
  output logic             ev_start,
  output logic             ev_refresh
);
  key_ev_e ev;

  always_comb begin
    ev = EV_NONE;
    if (key_wr) begin
      unique case (key_val)
        KEY_OPEN:    ev = EV_OPEN;
        KEY_CLOSE:   ev = EV_CLOSE;
        KEY_START:   ev = EV_START;
        KEY_REFRESH: ev = EV_REFRESH;
        default:     ev = EV_NONE;
      endcase
    end
  end

  assign ev_start   = (ev == EV_START);
  assign ev_refresh = (ev == EV_REFRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              unlocked <= 1'b0;
    else if (ev == EV_OPEN)  unlocked <= 1'b1;
    else if (ev == EV_CLOSE) unlocked <= 1'b0;
  end

  // R4: a key outside the defined set leaves the access state alone
  p_foreign_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val != KEY_OPEN && key_val != KEY_CLOSE) |=> $stable(unlocked));

  // R3: the opening key always leaves access open
  p_open_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val == KEY_OPEN) |=> unlocked);
endmodule

// File: rtl/kwd_shadow.sv
module kwd_shadow #(
  parameter int              W          = 12,
  parameter logic [W-1:0]    RST_VAL    = '0,
  parameter int              SYNC_TICKS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int CNT_W = $clog2(SYNC_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic             apply;

  assign apply = busy && tick && !wr_en && (cnt == CNT_W'(SYNC_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      busy   <= 1'b0;
      cnt    <= '0;
    end else if (wr_en) begin
      shadow <= wdata;
      busy   <= 1'b1;
      cnt    <= '0;
    end else if (apply) begin
      active <= shadow;
      busy   <= 1'b0;
      cnt    <= '0;
    end else if (busy && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: an accepted write raises the pending flag on the next cycle
  p_busy_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  // R7: the value in use changes only when the pending update lands
  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(active));

  p_apply_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (active == $past(shadow)) && !busy);
endmodule

// File: rtl/kwd_prediv.sv
module kwd_prediv
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = div_limit(code);
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R5: the smallest ratio is 4, so two ticks are never adjacent
  p_tick_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> !tick);

  // R9: a restart clears the phase so the next cycle cannot tick
  p_restart_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_refresh,
  input  logic             tick,
  input  logic [RLD_W-1:0] reload,
  output logic             running,
  output logic             rst_req
);
  logic [RLD_W-1:0] count;
  logic             expire;
  logic             load;

  assign load   = ev_start || ev_refresh;
  assign expire = running && tick && !load && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= RLD_RESET;
      running <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (ev_start) running <= 1'b1;
      if (load)                 count <= reload;
      else if (expire)          count <= reload;
      else if (running && tick) count <= count - 1'b1;
    end
  end

  // R10: the request never lasts longer than one cycle
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8: no request without a prior start
  p_pulse_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running);

  // R11: once running, always running
  p_run_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  // R9: refresh reloads the counter with the value in use
  p_refresh_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refresh |=> count == $past(reload));

  p_expire_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rst_req && (count == $past(reload)));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int SYNC_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_reset_req
);
  logic             wr_any;
  logic             wr_key;
  logic             wr_pre;
  logic             wr_rld;
  logic             unlocked;
  logic             ev_start;
  logic             ev_refresh;
  logic             tick;
  logic             running;
  logic [PRE_W-1:0] pre_shadow;
  logic [PRE_W-1:0] pre_active;
  logic             pre_busy;
  logic [RLD_W-1:0] rld_shadow;
  logic [RLD_W-1:0] rld_active;
  logic             rld_busy;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:KEY_W];

  assign wr_any = bus_sel && bus_wr;
  assign wr_key = wr_any && (bus_addr == ADDR_W'(OFS_KEY));
  assign wr_pre = wr_any && unlocked && (bus_addr == ADDR_W'(OFS_PRE));
  assign wr_rld = wr_any && unlocked && (bus_addr == ADDR_W'(OFS_RLD));

  kwd_keydec u_keydec (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (wr_key),
    .key_val    (bus_wdata[KEY_W-1:0]),
    .unlocked   (unlocked),
    .ev_start   (ev_start),
    .ev_refresh (ev_refresh)
  );

  kwd_shadow #(.W(PRE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_pre),
    .wdata  (bus_wdata[PRE_W-1:0]),
    .tick   (tick),
    .shadow (pre_shadow),
    .active (pre_active),
    .busy   (pre_busy)
  );

  kwd_shadow #(.W(RLD_W), .RST_VAL(RLD_RESET), .SYNC_TICKS(SYNC_TICKS)) u_rld (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_rld),
    .wdata  (bus_wdata[RLD_W-1:0]),
    .tick   (tick),
    .shadow (rld_shadow),
    .active (rld_active),
    .busy   (rld_busy)
  );

  kwd_prediv u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ev_start || ev_refresh),
    .code    (pre_active),
    .tick    (tick)
  );

  kwd_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_refresh (ev_refresh),
    .tick       (tick),
    .reload     (rld_active),
    .running    (running),
    .rst_req    (wdt_reset_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        ADDR_W'(OFS_PRE):  bus_rdata = {{(DATA_W-PRE_W){1'b0}}, pre_shadow};
        ADDR_W'(OFS_RLD):  bus_rdata = {{(DATA_W-RLD_W){1'b0}}, rld_shadow};
        ADDR_W'(OFS_STAT): bus_rdata = {{(DATA_W-2){1'b0}}, rld_busy, pre_busy};
        default:           bus_rdata = '0;
      endcase
    end
  end

  // R3: closed access leaves stored values and flags untouched
  p_locked_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !unlocked && bus_addr == ADDR_W'(OFS_PRE))
      |=> $stable(pre_shadow) && (pre_busy == $past(pre_busy) || !pre_busy));

  p_locked_rld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !unlocked && bus_addr == ADDR_W'(OFS_RLD)) |=> $stable(rld_shadow));

  // R2: the key register reads as zero
  p_key_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == ADDR_W'(OFS_KEY)) |-> bus_rdata == '0);

  // R8: a pulse only after the timer was started
  p_no_pulse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wdt_reset_req);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int SYNC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset_req;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int exp_q[$];
  bit mute = 1'b0;
  int t_w, t0, t2, t3, dummy;
  logic [31:0] rd;

  keyed_wdt #(.SYNC_TICKS(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_reset_req(wdt_reset_req)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    at = cyc;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // scoreboard monitor: every pulse must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && !mute) begin
      if (wdt_reset_req) begin
        pulses++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: pulse at cycle %0d, expected none", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            errors++;
            $display("FAIL R10: pulse at cycle %0d, expected %0d", cyc, e);
          end
        end
      end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        int e;
        e = exp_q.pop_front();
        checks++;
        errors++;
        $display("FAIL R10: no pulse at cycle %0d, expected one at %0d", cyc, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 reset request", {31'b0, wdt_reset_req}, 32'h0);
    brd(5'h04, rd); chk("R1 prescaler reset", rd, 32'h0);
    brd(5'h08, rd); chk("R1 reload reset", rd, 32'hFFF);
    brd(5'h0C, rd); chk("R1 status reset", rd, 32'h0);

    // R2 read-as-zero locations
    brd(5'h00, rd); chk("R2 key reads zero", rd, 32'h0);
    brd(5'h10, rd); chk("R2 window slot zero", rd, 32'h0);
    brd(5'h14, rd); chk("R2 unmapped zero", rd, 32'h0);

    // R3 closed access ignores writes
    bwr(5'h04, 32'h1, dummy);
    bwr(5'h08, 32'h5, dummy);
    brd(5'h04, rd); chk("R3 locked prescaler write ignored", rd, 32'h0);
    brd(5'h08, rd); chk("R3 locked reload write ignored", rd, 32'hFFF);
    brd(5'h0C, rd); chk("R3 locked write sets no flag", rd, 32'h0);

    // R4 foreign key does not open access
    bwr(5'h00, 32'h1234, dummy);
    bwr(5'h08, 32'h5, dummy);
    brd(5'h08, rd); chk("R4 foreign key does not unlock", rd, 32'hFFF);

    // open, then foreign key must not close again
    bwr(5'h00, 32'h5555, dummy);
    bwr(5'h00, 32'h1234, dummy);
    bwr(5'h08, 32'hFFFF_F003, t_w);
    brd(5'h08, rd); chk("R6 reload field 12 bits", rd, 32'h3);
    brd(5'h0C, rd); chk("R7 reload busy set", rd, 32'h2);

    // R7 latency lower and upper bound (divide 4)
    wait_until(t_w + (SYNC - 1) * 4 - 1);
    brd(5'h0C, rd); chk("R7 reload still busy", rd, 32'h2);
    for (int i = 0; i < 20; i++) begin
      brd(5'h0C, rd);
      if (rd == 32'h0) break;
    end
    chk("R7 reload busy cleared", rd, 32'h0);
    chk("R7 cleared in time", {31'b0, (cyc <= t_w + SYNC * 4 + 2)}, 32'h1);

    // R3 closing
    bwr(5'h00, 32'h0000, dummy);
    bwr(5'h08, 32'h7, dummy);
    brd(5'h08, rd); chk("R3 closed again", rd, 32'h3);

    // R8 nothing before start
    repeat (60) @(negedge clk);
    chk("R8 no pulse before start", pulses, 0);

    // R8/R10 start and periodic timeouts, (3+1)*4 = 16
    bwr(5'h00, 32'hCCCC, t0);
    for (int k = 1; k <= 4; k++) exp_q.push_back(t0 + 16 * k);
    wait_until(t0 + 56);
    bwr(5'h00, 32'h0000, dummy);   // R11 close key does not stop
    bwr(5'h00, 32'h1234, dummy);   // R4 foreign key does not refresh
    wait_until(t0 + 70);
    chk("R11 still running after close key", exp_q.size(), 0);
    chk("R10 four pulses", pulses, 4);

    // R9 refresh holds off the timeout
    for (int k = 0; k < 6; k++) begin
      bwr(5'h00, 32'hAAAA, t2);
      repeat (9) @(negedge clk);
    end
    bwr(5'h00, 32'hAAAA, t2);
    exp_q.push_back(t2 + 16);
    exp_q.push_back(t2 + 32);
    wait_until(t2 + 36);
    chk("R9 refresh realigns period", exp_q.size(), 0);
    chk("R9 no pulse during refresh run", pulses, 6);

    // R5 new divide ratio: mute while phase is unpredictable
    mute = 1'b1;
    bwr(5'h00, 32'h5555, dummy);
    bwr(5'h04, 32'hF9, dummy);
    brd(5'h04, rd); chk("R5 prescaler field 3 bits", rd, 32'h1);
    brd(5'h0C, rd); chk("R7 prescaler busy set", rd, 32'h1);
    for (int i = 0; i < 40; i++) begin
      brd(5'h0C, rd);
      if (rd == 32'h0) break;
    end
    chk("R7 prescaler busy cleared", rd, 32'h0);
    bwr(5'h00, 32'h0000, dummy);
    bwr(5'h00, 32'hAAAA, t3);
    exp_q.delete();
    @(negedge clk);
    mute = 1'b0;
    exp_q.push_back(t3 + 32);
    exp_q.push_back(t3 + 64);
    wait_until(t3 + 70);
    chk("R5 divide-by-8 period", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule